// File: doc/BRIEF.md
# Burst Pattern Generator

This block stands in for a detector front end during bring-up and throughput tests. It emits pseudo-random 16-bit words over a ready/valid stream and groups them into packets. Four configuration inputs set it up: a run enable, the number of packets, the number of words in each packet, and an idle gap between packets. The gap is counted in pulses of a slow-clock enable input. A last-word flag marks the end of each packet. A done flag rises after the final packet, and the generator then stops until the enable is taken away.

The words come from a 16-bit maximal-length shift register. It is seeded at reset and steps only when a word is accepted. It is never re-seeded, so the sequence carries on across packets and across runs. The configuration inputs must be held steady while the enable is high.

The controller has four states. ST_IDLE waits for the enable and clears all counters. ST_SEND presents words. ST_GAP waits out the inter-packet delay. ST_DONE holds the done flag. The transitions are:
- IDLE→SEND on enable, when both counts are nonzero.
- IDLE→DONE on enable, when either count is zero.
- SEND→GAP when the last word of a packet that is not the final packet is accepted.
- SEND→DONE when the last word of the final packet is accepted.
- SEND→IDLE when a word is accepted while the enable is low.
- GAP→SEND once the gap counter equals the programmed delay.
- GAP→IDLE and DONE→IDLE when the enable is low.

Top module: `burst_pattern_gen`

## Requirements
- R1: While reset is low and just after it, out_valid and done are 0, and out_data shows the seed 16'hACE1.
- R2: The first word after reset is 16'hACE1. Each later word is derived from the word before it as {x[14:0], x[15]^x[13]^x[12]^x[10]}.
- R3: Once out_valid is high, out_valid and out_data hold their values until out_ready is seen high on a clock edge.
- R4: Every packet carries exactly pkt_words words. out_last is 1 on the final word of a packet and 0 on all other words.
- R5: After pkt_count packets, done goes to 1 and out_valid stays at 0. done stays at 1 while run_en is high, and returns to 0 within two cycles after run_en goes low.
- R6: Between packets, out_valid is low. The number of slow_tick pulses seen in that gap is gap_ticks or gap_ticks+1. A gap of 0 leaves a single idle cycle.
- R7: If pkt_count or pkt_words is 0, enabling the block produces no valid word and raises done within two cycles.
- R8: If run_en drops in the middle of a run, the word on offer stays valid until it is accepted. Then out_valid and done are 0, and the next run starts with the full packet count.
- R9: The shift register is never re-seeded between packets or between runs. Only an accepted word advances it.
- R10: A valid word is never zero, and out_last is never high without out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable |
| pkt_count | input | 9 | Packets per run |
| pkt_words | input | 9 | Words per packet |
| gap_ticks | input | 16 | Inter-packet delay in slow_tick pulses |
| slow_tick | input | 1 | Slow-clock enable pulse |
| out_ready | input | 1 | Sink accepts the current word |
| out_valid | output | 1 | Word on out_data is valid |
| out_data | output | 16 | Pseudo-random word |
| out_last | output | 1 | Final word of a packet |
| done | output | 1 | Run finished |

## Verification
The checker watches four things on every cycle:
- valid and data stay put under backpressure;
- done and valid are never high together;
- out_last only appears with a valid word, and valid words are never zero;
- each accepted word changes the data.

The bench scenarios cover what no single-cycle property can show:
- the exact word sequence against an independent model of the shift register;
- packet lengths and counts;
- the number of slow ticks in each gap;
- the zero-count cases, and a restart after an abort taking the full count again.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } pbg_state_e;

    localparam logic [15:0] PBG_SEED = 16'hACE1;
    localparam logic [15:0] PBG_TAPS = 16'hB400;
endpackage

// File: rtl/pbg_lfsr.sv
module pbg_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = '1,
    parameter logic [W-1:0] TAPS = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] q
);
    logic fb;

    always_comb fb = ^(q & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= SEED;
        else if (step) q <= {q[W-2:0], fb};
    end
endmodule

// File: rtl/pbg_counter.sv
module pbg_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (inc)      q <= q + 1'b1;
    end
endmodule

// File: rtl/burst_pattern_gen.sv
module burst_pattern_gen
    import pbg_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COUNT_W = 9,
    parameter int GAP_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [COUNT_W-1:0] pkt_count,
    input  logic [COUNT_W-1:0] pkt_words,
    input  logic [GAP_W-1:0]   gap_ticks,
    input  logic               slow_tick,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_last,
    output logic               done
);
    localparam int EXT_W = COUNT_W + 1;

    pbg_state_e st, nxt;

    logic               word_clr, word_inc, pkt_clr, pkt_inc, gap_clr, gap_inc;
    logic [COUNT_W-1:0] word_q, pkt_q;
    logic [GAP_W-1:0]   gap_q;
    logic               word_last, pkt_last, cfg_empty, accept;

    pbg_lfsr #(.W(DATA_W), .SEED(PBG_SEED[DATA_W-1:0]), .TAPS(PBG_TAPS[DATA_W-1:0])) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(accept), .q(out_data)
    );

    pbg_counter #(.W(COUNT_W)) u_word_cnt (
        .clk(clk), .rst_n(rst_n), .clr(word_clr), .inc(word_inc), .q(word_q)
    );
    pbg_counter #(.W(COUNT_W)) u_pkt_cnt (
        .clk(clk), .rst_n(rst_n), .clr(pkt_clr), .inc(pkt_inc), .q(pkt_q)
    );
    pbg_counter #(.W(GAP_W)) u_gap_cnt (
        .clk(clk), .rst_n(rst_n), .clr(gap_clr), .inc(gap_inc), .q(gap_q)
    );

    always_comb begin
        word_last = ({1'b0, word_q} + EXT_W'(1)) == {1'b0, pkt_words};
        pkt_last  = ({1'b0, pkt_q} + EXT_W'(1)) == {1'b0, pkt_count};
        cfg_empty = (pkt_count == '0) || (pkt_words == '0);
        accept    = (st == ST_SEND) && out_ready;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state and counter controls
    always_comb begin
        nxt      = st;
        word_clr = 1'b0;
        word_inc = 1'b0;
        pkt_clr  = 1'b0;
        pkt_inc  = 1'b0;
        gap_clr  = 1'b0;
        gap_inc  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                word_clr = 1'b1;
                pkt_clr  = 1'b1;
                gap_clr  = 1'b1;
                if (run_en) nxt = cfg_empty ? ST_DONE : ST_SEND;
            end
            ST_SEND: begin
                if (accept) begin
                    if (!run_en) begin
                        nxt = ST_IDLE;
                    end else if (word_last) begin
                        word_clr = 1'b1;
                        if (pkt_last) begin
                            nxt = ST_DONE;
                        end else begin
                            pkt_inc = 1'b1;
                            gap_clr = 1'b1;
                            nxt     = ST_GAP;
                        end
                    end else begin
                        word_inc = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (!run_en)                 nxt = ST_IDLE;
                else if (gap_q == gap_ticks) nxt = ST_SEND;
                else if (slow_tick)          gap_inc = 1'b1;
            end
            ST_DONE: begin
                if (!run_en) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = (st == ST_SEND);
        out_last  = (st == ST_SEND) && word_last;
        done      = (st == ST_DONE);
    end
endmodule

// File: rtl/burst_pattern_gen_checker.sv
module burst_pattern_gen_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              out_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              done
);
    assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_no_word_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && out_valid));

    assert_last_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_word_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data != '0);

    assert_step_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> out_data != $past(out_data));

    assert_done_rises_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run_en));
endmodule

bind burst_pattern_gen burst_pattern_gen_checker #(.DATA_W(DATA_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .done(done)
);

// File: tb/burst_pattern_gen_test.sv
module burst_pattern_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [8:0]  pkt_count = '0;
    logic [8:0]  pkt_words = '0;
    logic [15:0] gap_ticks = '0;
    logic        slow_tick = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid, out_last, done;
    logic [15:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [15:0] model = 16'hACE1;

    // {count, words, gap, ready_mode}
    localparam logic [35:0] VEC [0:4] = '{
        {9'd3, 9'd4, 16'd5, 2'd0},
        {9'd2, 9'd6, 16'd0, 2'd1},
        {9'd4, 9'd1, 16'd2, 2'd2},
        {9'd1, 9'd9, 16'd0, 2'd0},
        {9'd2, 9'd3, 16'd1, 2'd1}
    };

    always #10 clk = ~clk;

    burst_pattern_gen uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pkt_count(pkt_count),
        .pkt_words(pkt_words), .gap_ticks(gap_ticks), .slow_tick(slow_tick),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .done(done)
    );

    function automatic logic [15:0] adv(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic rdy);
        @(negedge clk);
        cyc++;
        out_ready = rdy;
        slow_tick = (cyc % 3 == 0);
        #1;
    endtask

    function automatic logic rdy_for(input logic [1:0] mode, input int c);
        case (mode)
            2'd1:    return c[0];
            2'd2:    return (c % 3) == 0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic run_cfg(input int cnt, input int words, input int gap, input logic [1:0] mode);
        int  widx = 0;
        int  pkts = 0;
        int  ticks = 0;
        bit  in_gap = 0;
        bit  fin = 0;
        pkt_count = 9'(cnt);
        pkt_words = 9'(words);
        gap_ticks = 16'(gap);
        run_en = 1'b1;
        for (int n = 0; n < 4000 && !fin; n++) begin
            step(rdy_for(mode, cyc + 1));
            if (out_valid && in_gap) begin
                chk(ticks == gap || ticks == gap + 1, "R6", "gap ticks", ticks, gap);
                in_gap = 0;
            end
            if (!out_valid && in_gap) ticks += int'(slow_tick);
            if (out_valid && out_ready) begin
                chk(out_data == model, "R2", "word value", out_data, model);
                chk(out_last == (widx == words - 1), "R4", "last flag", out_last, widx == words - 1);
                model = adv(model);
                widx++;
                if (widx == words) begin
                    pkts++;
                    widx = 0;
                    in_gap = 1;
                    ticks = 0;
                end
            end
            if (done) fin = 1;
        end
        chk(fin, "R5", "done reached", fin, 1);
        chk(pkts == cnt, "R5", "packet count", pkts, cnt);
        for (int k = 0; k < 3; k++) begin
            step(1'b1);
            chk(done && !out_valid, "R5", "done held", {done, out_valid}, 2'b10);
        end
        run_en = 1'b0;
        step(1'b1);
        step(1'b1);
        chk(!done, "R5", "done cleared", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) step(1'b0);
        chk(!out_valid && !done, "R1", "reset outputs", {out_valid, done}, 0);
        chk(out_data == 16'hACE1, "R1", "seed in reset", out_data, 16'hACE1);
        rst_n = 1'b1;
        step(1'b0);
        chk(!out_valid && !done && out_data == 16'hACE1, "R1", "after reset", out_data, 16'hACE1);

        // table of scenarios (R2 R4 R5 R6 R9)
        for (int v = 0; v < 5; v++)
            run_cfg(int'(VEC[v][35:27]), int'(VEC[v][26:18]), int'(VEC[v][17:2]), VEC[v][1:0]);

        // R7 zero packet count, then zero packet size
        for (int z = 0; z < 2; z++) begin
            bit seen = 0;
            pkt_count = (z == 0) ? 9'd0 : 9'd3;
            pkt_words = (z == 0) ? 9'd4 : 9'd0;
            run_en = 1'b1;
            step(1'b1); seen |= out_valid;
            step(1'b1); seen |= out_valid;
            chk(done && !seen, "R7", "zero config", {done, seen}, 2'b10);
            run_en = 1'b0;
            step(1'b1);
            step(1'b1);
            chk(out_data == model, "R9", "no step on empty run", out_data, model);
        end

        // R8 abort mid-run with backpressure (R3 hold)
        begin
            logic [15:0] held;
            pkt_count = 9'd2;
            pkt_words = 9'd5;
            gap_ticks = 16'd0;
            run_en = 1'b1;
            step(1'b0);
            step(1'b0);
            held = out_data;
            chk(out_valid && held == model, "R3", "word offered", held, model);
            run_en = 1'b0;
            step(1'b0);
            chk(out_valid && out_data == held, "R8", "held after abort", out_data, held);
            step(1'b0);
            chk(out_valid && out_data == held, "R3", "stall hold", out_data, held);
            step(1'b1);
            chk(out_valid && out_ready, "R8", "final accept", out_valid, 1);
            model = adv(model);
            step(1'b0);
            chk(!out_valid && !done, "R8", "idle after abort", {out_valid, done}, 0);
            chk(out_data == model, "R9", "state kept after abort", out_data, model);
        end
        run_cfg(1, 2, 0, 2'd0);  // R8 fresh run after abort

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule